// File: doc/BRIEF.md
# Real-Time Timebase Interval Timer

This block is a clock-keeping timebase. A single wide counter advances once for every tick strobe that comes from the selected time source. That source is either the system clock divided by 128 or a 32768 Hz slow clock. The counter wraps when it reaches the length of the chosen period, and each wrap raises an interrupt flag. The flag stays set until software clears it. The same counter produces the power-of-two sub-second periods and also a one-minute period, which is not a power of two.

The block also has a wake request. This output follows the interrupt flag, but only while the timer runs from the slow clock. This matches the way the timer keeps running while the processor idles: when the fast clock is the source, it is stopped during idle, so it cannot wake the processor. The oscillators and the interrupt controller are outside this block.

Top module: `rtb_timer`

## Requirements
- R1: After a synchronous reset, `irq_flag` and `wake_req` are 0 and the count restarts from zero.
- R2: With `period_sel` = 3 (eighth of a second), `irq_flag` rises on exactly every TICKS_PER_SEC/8-th accepted tick.
- R3: With `period_sel` = 2 (half second), the interval is TICKS_PER_SEC/2 ticks.
- R4: With `period_sel` = 1 (one second), the interval is TICKS_PER_SEC ticks.
- R5: With `period_sel` = 0 (one minute), the interval is 60*TICKS_PER_SEC ticks. The counter wraps there and never holds a value at or above that length.
- R6: `irq_flag` is sticky. It stays at 1 through further ticks until `irq_clear` is high in a cycle with no new event, and it is 0 in the following cycle.
- R7: If `irq_clear` arrives in the same cycle as a period event, `irq_flag` stays set.
- R8: Any change of `period_sel` resets the count to zero, so the first interval after the change is a full interval of the new period.
- R9: `wake_req` equals `irq_flag` when `src_slow` = 1, and is 0 when `src_slow` = 0.
- R10: Only the strobe of the selected source counts: `tick_slow` when `src_slow` = 1, and `tick_sys` when `src_slow` = 0. The other strobe has no effect on the count.
- R11: While `enable` is 0, no ticks are counted and the count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_sys | input | 1 | One-cycle strobe at system clock / 128 |
| tick_slow | input | 1 | One-cycle strobe at the slow-clock rate |
| src_slow | input | 1 | 1 selects the slow-clock strobe, 0 the divided system strobe |
| period_sel | input | 2 | 0 = one minute, 1 = one second, 2 = half second, 3 = eighth second |
| enable | input | 1 | Counting enable |
| irq_clear | input | 1 | Clears the sticky interrupt flag |
| irq_flag | output | 1 | Sticky period interrupt flag |
| wake_req | output | 1 | Wake request, only active when the slow clock is the source |

## Verification
The bench counts ticks between flag rises for all four periods and checks the second interval too. An off-by-one in the wrap compare, or a counter that misses the non-power-of-two minute wrap, shows up as a wrong interval. It applies a clear in the same cycle as an event, which a clear-wins flag would lose. It changes the period mid-count, which a design that keeps the old count would end early. It also toggles the unselected strobe and the enable; a design that lets either reach the counter would end the next interval early. Wake is checked for both source settings, which catches a wake raised from the fast source.

// File: rtl/rtb_pkg.sv
package rtb_pkg;

    typedef enum logic [1:0] {
        PER_MINUTE = 2'd0,
        PER_SECOND = 2'd1,
        PER_HALF   = 2'd2,
        PER_EIGHTH = 2'd3
    } period_e;

    typedef struct packed {
        logic tick;
        logic slow;
    } tick_t;

    typedef struct packed {
        logic evt;
        logic restart;
    } cnt_status_t;

    function automatic int unsigned period_len(period_e p, int unsigned tps);
        case (p)
            PER_MINUTE: return 60 * tps;
            PER_SECOND: return tps;
            PER_HALF:   return tps / 2;
            default:    return tps / 8;
        endcase
    endfunction

endpackage

// File: rtl/rtb_tick_select.sv
module rtb_tick_select
    import rtb_pkg::*;
(
    input  logic  tick_sys,
    input  logic  tick_slow,
    input  logic  src_slow,
    output tick_t tk
);
    always_comb begin
        tk.slow = src_slow;
        tk.tick = src_slow ? tick_slow : tick_sys;
    end
endmodule

// File: rtl/rtb_counter.sv
module rtb_counter
    import rtb_pkg::*;
#(
    parameter int unsigned CNT_W         = 21,
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  period_e     period,
    input  tick_t       tk,
    output cnt_status_t st
);
    localparam logic [CNT_W-1:0] LAST_MIN  = CNT_W'(period_len(PER_MINUTE, TICKS_PER_SEC) - 1);
    localparam logic [CNT_W-1:0] LAST_SEC  = CNT_W'(period_len(PER_SECOND, TICKS_PER_SEC) - 1);
    localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(period_len(PER_HALF,   TICKS_PER_SEC) - 1);
    localparam logic [CNT_W-1:0] LAST_EGTH = CNT_W'(period_len(PER_EIGHTH, TICKS_PER_SEC) - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    period_e          period_q;

    always_comb begin
        case (period)
            PER_MINUTE: last = LAST_MIN;
            PER_SECOND: last = LAST_SEC;
            PER_HALF:   last = LAST_HALF;
            default:    last = LAST_EGTH;
        endcase
    end

    always_comb begin
        st.restart = !enable || (period != period_q);
        st.evt     = !st.restart && tk.tick && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        period_q <= period;
        if (rst || st.restart) begin
            cnt_q <= '0;
        end else if (tk.tick) begin
            cnt_q <= st.evt ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        !st.restart |-> cnt_q <= last) else $error("count past wrap"); // R5
    AST_SEL_RESTART: assert property (@(posedge clk) disable iff (rst)
        (period != $past(period)) |=> cnt_q == '0) else $error("no restart on period change"); // R8
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !enable |=> cnt_q == '0) else $error("counting while disabled"); // R11
endmodule

// File: rtl/rtb_irq.sv
module rtb_irq
    import rtb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cnt_status_t st,
    input  tick_t       tk,
    input  logic        irq_clear,
    output logic        irq_flag,
    output logic        wake_req
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (st.evt) flag_q <= 1'b1;
        else if (irq_clear) flag_q <= 1'b0;
    end

    assign irq_flag = flag_q;
    assign wake_req = flag_q & tk.slow;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        st.evt |=> flag_q) else $error("event lost"); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_q && !irq_clear |=> flag_q) else $error("flag dropped"); // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        irq_clear && !st.evt |=> !flag_q) else $error("clear ignored"); // R6
endmodule

// File: rtl/rtb_timer.sv
module rtb_timer
    import rtb_pkg::*;
#(
    parameter int unsigned CNT_W         = 21,
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_sys,
    input  logic       tick_slow,
    input  logic       src_slow,
    input  logic [1:0] period_sel,
    input  logic       enable,
    input  logic       irq_clear,
    output logic       irq_flag,
    output logic       wake_req
);
    tick_t       tk;
    cnt_status_t st;

    rtb_tick_select u_sel (
        .tick_sys  (tick_sys),
        .tick_slow (tick_slow),
        .src_slow  (src_slow),
        .tk        (tk)
    );

    rtb_counter #(
        .CNT_W         (CNT_W),
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .period (period_e'(period_sel)),
        .tk     (tk),
        .st     (st)
    );

    rtb_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .tk        (tk),
        .irq_clear (irq_clear),
        .irq_flag  (irq_flag),
        .wake_req  (wake_req)
    );

    AST_WAKE_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> irq_flag && src_slow) else $error("wake without slow source"); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !irq_flag) else $error("flag after reset"); // R1
endmodule

// File: tb/rtb_timer_test.sv
module rtb_timer_test;
    localparam int unsigned TPS = 64;

    logic clk = 1'b0;
    logic rst, tick_sys, tick_slow, src_slow, enable, irq_clear;
    logic [1:0] period_sel;
    logic irq_flag, wake_req;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtb_timer #(.CNT_W(21), .TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst(rst), .tick_sys(tick_sys), .tick_slow(tick_slow),
        .src_slow(src_slow), .period_sel(period_sel), .enable(enable),
        .irq_clear(irq_clear), .irq_flag(irq_flag), .wake_req(wake_req)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one strobe on the chosen line, then a quiet cycle
    task automatic pulse(bit on_slow);
        @(negedge clk);
        if (on_slow) tick_slow = 1'b1; else tick_sys = 1'b1;
        @(negedge clk);
        tick_slow = 1'b0;
        tick_sys  = 1'b0;
    endtask

    task automatic pulses(bit on_slow, int n);
        for (int i = 0; i < n; i++) pulse(on_slow);
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!irq_flag && n < 5000) begin
            pulse(src_slow);
            n++;
        end
    endtask

    task automatic restart(bit slow, logic [1:0] sel);
        @(negedge clk);
        enable = 1'b0; irq_clear = 1'b1; src_slow = slow; period_sel = sel;
        @(negedge clk);
        enable = 1'b1; irq_clear = 1'b0;
    endtask

    task automatic clear_flag;
        @(negedge clk); irq_clear = 1'b1;
        @(negedge clk); irq_clear = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 flag", irq_flag, 0);
        check("R1 wake", wake_req, 0);
    endtask

    task automatic t_interval(string req, logic [1:0] sel, int exp, bit slow);
        int n;
        restart(slow, sel);
        measure(n);
        check({req, " first interval"}, n, exp);
        clear_flag();
        measure(n);
        check({req, " second interval"}, n, exp);
        clear_flag();
    endtask

    task automatic t_sticky_and_clash;
        int n;
        restart(1'b1, 2'd3);
        measure(n);
        pulses(1'b1, TPS / 8 - 1);
        check("R6 sticky after ticks", irq_flag, 1);
        // R7: clear in the same cycle as the next event
        @(negedge clk);
        tick_slow = 1'b1; irq_clear = 1'b1;
        @(negedge clk);
        tick_slow = 1'b0; irq_clear = 1'b0;
        check("R7 clear with event", irq_flag, 1);
        clear_flag();
        check("R6 cleared", irq_flag, 0);
    endtask

    task automatic t_period_change;
        int n;
        restart(1'b1, 2'd3);
        pulses(1'b1, 5);
        @(negedge clk); period_sel = 2'd2;
        measure(n);
        check("R8 full interval after change", n, TPS / 2);
        clear_flag();
    endtask

    task automatic t_wake;
        int n;
        restart(1'b0, 2'd3);
        measure(n);
        check("R9 flag on system source", irq_flag, 1);
        check("R9 no wake on system source", wake_req, 0);
        @(negedge clk); src_slow = 1'b1;
        @(negedge clk);
        check("R9 wake on slow source", wake_req, 1);
        clear_flag();
        check("R9 wake drops with flag", wake_req, 0);
    endtask

    task automatic t_other_source;
        int n;
        restart(1'b1, 2'd3);
        pulses(1'b0, 3 * TPS / 8);
        check("R10 system strobe ignored on slow", irq_flag, 0);
        measure(n);
        check("R10 slow interval intact", n, TPS / 8);
        clear_flag();
        restart(1'b0, 2'd3);
        pulses(1'b1, 3 * TPS / 8);
        check("R10 slow strobe ignored on system", irq_flag, 0);
        measure(n);
        check("R10 system interval intact", n, TPS / 8);
        clear_flag();
    endtask

    task automatic t_enable;
        int n;
        restart(1'b1, 2'd3);
        @(negedge clk); enable = 1'b0;
        pulses(1'b1, 3 * TPS / 8);
        check("R11 no event while disabled", irq_flag, 0);
        @(negedge clk); enable = 1'b1;
        pulses(1'b1, 5);
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
        measure(n);
        check("R11 count held at zero", n, TPS / 8);
        clear_flag();
    endtask

    initial begin
        rst = 1'b1; tick_sys = 0; tick_slow = 0; src_slow = 1;
        period_sel = 2'd3; enable = 0; irq_clear = 0;
        t_reset();
        t_interval("R2", 2'd3, TPS / 8, 1'b1);
        t_interval("R3", 2'd2, TPS / 2, 1'b1);
        t_interval("R4", 2'd1, TPS, 1'b0);
        t_interval("R5", 2'd0, 60 * TPS, 1'b1);
        t_sticky_and_clash();
        t_period_change();
        t_wake();
        t_other_source();
        t_enable();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule